// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sequences low-power states for a small microcontroller core. Software programs a control register holding a sleep-enable flag and a two-bit mode code. When the CPU then executes its sleep instruction it pulses a strobe. If sleep is enabled at that moment, the controller gates a mode-dependent set of clock domains: CPU, flash, I/O, ADC and asynchronous peripherals. In the deepest mode it also drops the oscillator enable.

While asleep, the controller masks the incoming wake requests according to the mode in force. On an accepted wake it restarts the oscillator when the oscillator was stopped, counting a parameterised number of ticks of a free-running asynchronous clock. It then re-enables every clock and holds the CPU for four more cycles. Finally it pulses one of two outputs: one tells the CPU to service the interrupt and resume after the sleep instruction, the other tells it to restart from the reset vector when the wake came from a reset source.

Top module: `sleep_power_ctrl`

## Requirements
- R1: A sleep strobe while the sleep-enable bit is zero is ignored: the CPU is not held, all clocks stay enabled and no ADC start pulse is issued.
- R2: The control register resets to zero. A write stores bit 5 as sleep enable and bits 4:3 as the mode code. Bit 2 and every other bit read zero whatever was written.
- R3: Mode code 00 (light idle) gates the CPU and flash clocks, keeps the I/O, ADC and asynchronous clocks and the oscillator on, and any of the seven wake inputs wakes the core.
- R4: Mode code 01 (quiet conversion) gates the CPU, flash and I/O clocks and keeps the ADC and asynchronous clocks on. Only wake bits 0, 1, 2, 4 and 5 wake the core; bit 3 (edge-type external interrupt) and bit 6 (other I/O interrupts) are ignored.
- R5: Mode code 10 (deep off) gates all five clocks and drops the oscillator enable. Only wake bits 2 (level-type external interrupt), 4 (pin change) and 5 (watchdog) or a reset request wake the core.
- R6: Mode code 11 (warm off) gates clocks and filters wakes like code 10, but keeps the oscillator enable high, so no start-up wait occurs.
- R7: After a wake from code 10, the oscillator enable rises at once, while the clocks stay gated until STARTUP_TICKS cycles with the asynchronous tick high have been counted.
- R8: Sleep entry in code 00 or 01 with the ADC enable input high gives a one-cycle ADC start pulse in the first sleeping cycle. Codes 10 and 11 give none.
- R9: On an interrupt wake all clocks are enabled and the CPU is held for exactly four cycles. Then the interrupt-resume output pulses for one cycle as the hold drops.
- R10: A reset request while asleep wakes the core and takes priority over interrupts. The reset-vector output pulses (after the start-up wait in code 10) with no four-cycle hold, and the interrupt-resume output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read data |
| sleepInstr | input | 1 | One-cycle pulse from the CPU's sleep instruction |
| adcEnable | input | 1 | ADC is enabled |
| wakeReq | input | 7 | Wake requests: 0 ADC done, 1 NVM ready, 2 INT0 level, 3 INT0 edge, 4 pin change, 5 watchdog, 6 other I/O |
| rstReq | input | 1 | A reset source (pin, watchdog, brown-out) is requesting |
| asyncTick | input | 1 | Synchronised tick of the free-running asynchronous clock |
| clkEnCpu | output | 1 | CPU clock enable |
| clkEnFlash | output | 1 | Flash clock enable |
| clkEnIo | output | 1 | I/O clock enable |
| clkEnAdc | output | 1 | ADC clock enable |
| clkEnAsync | output | 1 | Asynchronous peripheral clock enable |
| oscEn | output | 1 | Main oscillator enable |
| adcStart | output | 1 | One-cycle ADC conversion start |
| cpuHold | output | 1 | CPU must stay stalled |
| irqGo | output | 1 | One-cycle pulse: service the wake interrupt |
| rstVecGo | output | 1 | One-cycle pulse: restart from the reset vector |

## Verification
The hardest situation to reach is a reset request arriving together with an interrupt while the deep-off start-up count is running. The stimulus holds the asynchronous tick low across the wake, which freezes the sequence in the start-up phase. It then releases the tick one cycle at a time, so the exact cycle where the clocks return and the reset-vector pulse fires can be observed. A table of mode and wake-bit pairs sweeps the accepted and rejected sources of every mode. After each rejected source the bench wakes the core with the watchdog bit and lets it return to active.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int WAKE_W = 7;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_QUIET = 2'b01,
    MODE_DEEP  = 2'b10,
    MODE_WARM  = 2'b11
  } sleepMode_t;

  typedef enum logic [1:0] {
    PH_RUN   = 2'b00,
    PH_SLEEP = 2'b01,
    PH_START = 2'b10,
    PH_HALT  = 2'b11
  } phase_t;

  // control -> datapath strobes
  typedef struct packed {
    phase_t phase;
    logic   enter;
    logic   takeWake;
    logic   cntStart;
    logic   cntHalt;
  } spcStrobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic seBit;
    logic wakeHit;
    logic rstHit;
    logic needOsc;
    logic startDone;
    logic haltDone;
    logic wakeIsRst;
  } spcFlag_t;

  localparam logic [WAKE_W-1:0] MASK_IDLE  = 7'b111_1111;
  localparam logic [WAKE_W-1:0] MASK_QUIET = 7'b011_0111;
  localparam logic [WAKE_W-1:0] MASK_OFF   = 7'b011_0100;
endpackage

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int STARTUP_TICKS = 16,
  parameter int HALT_CYCLES   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              adcEnable,
  input  logic [WAKE_W-1:0] wakeReq,
  input  logic              rstReq,
  input  logic              asyncTick,
  input  spcStrobe_t        strobe,
  output spcFlag_t          flag,
  output logic [4:0]        clkEn,
  output logic              oscEn,
  output logic              adcStart
);
  localparam int START_W = (STARTUP_TICKS > 1) ? $clog2(STARTUP_TICKS) : 1;
  localparam int HALT_W  = (HALT_CYCLES > 1) ? $clog2(HALT_CYCLES) : 1;
  localparam logic [START_W-1:0] START_LAST = START_W'(STARTUP_TICKS - 1);
  localparam logic [HALT_W-1:0]  HALT_LAST  = HALT_W'(HALT_CYCLES - 1);

  logic               seBit;
  sleepMode_t         cfgMode;
  sleepMode_t         sleepMode;
  logic               wakeIsRst;
  logic [START_W-1:0] startCnt;
  logic [HALT_W-1:0]  haltCnt;
  logic [WAKE_W-1:0]  wakeMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seBit   <= 1'b0;
      cfgMode <= MODE_IDLE;
    end else if (regWrEn) begin
      seBit   <= regWrData[5];
      cfgMode <= sleepMode_t'(regWrData[4:3]);
    end
  end

  assign regRdData = {2'b00, seBit, cfgMode, 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepMode <= MODE_IDLE;
      adcStart  <= 1'b0;
    end else begin
      adcStart <= 1'b0;
      if (strobe.enter) begin
        sleepMode <= cfgMode;
        adcStart  <= adcEnable && !cfgMode[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeIsRst <= 1'b0;
      startCnt  <= '0;
      haltCnt   <= '0;
    end else if (strobe.takeWake) begin
      wakeIsRst <= rstReq;
      startCnt  <= '0;
      haltCnt   <= '0;
    end else begin
      if (strobe.cntStart && asyncTick) startCnt <= startCnt + 1'b1;
      if (strobe.cntHalt) haltCnt <= haltCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (sleepMode)
      MODE_IDLE:  wakeMask = MASK_IDLE;
      MODE_QUIET: wakeMask = MASK_QUIET;
      default:    wakeMask = MASK_OFF;
    endcase
  end

  assign flag.seBit     = seBit;
  assign flag.wakeHit   = |(wakeReq & wakeMask);
  assign flag.rstHit    = rstReq;
  assign flag.needOsc   = (sleepMode == MODE_DEEP);
  assign flag.startDone = asyncTick && (startCnt == START_LAST);
  assign flag.haltDone  = (haltCnt == HALT_LAST);
  assign flag.wakeIsRst = wakeIsRst;

  // clkEn order: {cpu, flash, io, adc, async}
  always_comb begin
    clkEn = 5'b11111;
    oscEn = 1'b1;
    unique case (strobe.phase)
      PH_SLEEP: begin
        unique case (sleepMode)
          MODE_IDLE:  clkEn = 5'b00111;
          MODE_QUIET: clkEn = 5'b00011;
          MODE_DEEP: begin
            clkEn = 5'b00000;
            oscEn = 1'b0;
          end
          default:    clkEn = 5'b00000;
        endcase
      end
      PH_START: clkEn = 5'b00000;
      default:  clkEn = 5'b11111;
    endcase
  end
endmodule

// File: rtl/spc_control.sv
module spc_control
  import spc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepInstr,
  input  spcFlag_t   flag,
  output spcStrobe_t strobe,
  output logic       cpuHold,
  output logic       irqGo,
  output logic       rstVecGo
);
  phase_t phase, phaseNext;
  logic   irqNext, rstNext;

  always_comb begin
    phaseNext       = phase;
    irqNext         = 1'b0;
    rstNext         = 1'b0;
    strobe.enter    = 1'b0;
    strobe.takeWake = 1'b0;
    strobe.cntStart = 1'b0;
    strobe.cntHalt  = 1'b0;
    unique case (phase)
      PH_RUN: begin
        if (sleepInstr && flag.seBit) begin
          strobe.enter = 1'b1;
          phaseNext    = PH_SLEEP;
        end
      end
      PH_SLEEP: begin
        if (flag.rstHit || flag.wakeHit) begin
          strobe.takeWake = 1'b1;
          if (flag.needOsc) begin
            phaseNext = PH_START;
          end else if (flag.rstHit) begin
            phaseNext = PH_RUN;
            rstNext   = 1'b1;
          end else begin
            phaseNext = PH_HALT;
          end
        end
      end
      PH_START: begin
        strobe.cntStart = 1'b1;
        if (flag.startDone) begin
          if (flag.wakeIsRst) begin
            phaseNext = PH_RUN;
            rstNext   = 1'b1;
          end else begin
            phaseNext = PH_HALT;
          end
        end
      end
      default: begin
        strobe.cntHalt = 1'b1;
        if (flag.haltDone) begin
          phaseNext = PH_RUN;
          irqNext   = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_RUN;
      irqGo    <= 1'b0;
      rstVecGo <= 1'b0;
    end else begin
      phase    <= phaseNext;
      irqGo    <= irqNext;
      rstVecGo <= rstNext;
    end
  end

  assign strobe.phase = phase;
  assign cpuHold      = (phase != PH_RUN);
endmodule

// File: rtl/sleep_power_ctrl.sv
module sleep_power_ctrl
  import spc_pkg::*;
#(
  parameter int STARTUP_TICKS = 16,
  parameter int HALT_CYCLES   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              sleepInstr,
  input  logic              adcEnable,
  input  logic [WAKE_W-1:0] wakeReq,
  input  logic              rstReq,
  input  logic              asyncTick,
  output logic              clkEnCpu,
  output logic              clkEnFlash,
  output logic              clkEnIo,
  output logic              clkEnAdc,
  output logic              clkEnAsync,
  output logic              oscEn,
  output logic              adcStart,
  output logic              cpuHold,
  output logic              irqGo,
  output logic              rstVecGo
);
  spcStrobe_t strobe;
  spcFlag_t   flag;
  logic [4:0] clkEn;

  spc_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sleepInstr (sleepInstr),
    .flag       (flag),
    .strobe     (strobe),
    .cpuHold    (cpuHold),
    .irqGo      (irqGo),
    .rstVecGo   (rstVecGo)
  );

  spc_datapath #(
    .STARTUP_TICKS (STARTUP_TICKS),
    .HALT_CYCLES   (HALT_CYCLES)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .adcEnable (adcEnable),
    .wakeReq   (wakeReq),
    .rstReq    (rstReq),
    .asyncTick (asyncTick),
    .strobe    (strobe),
    .flag      (flag),
    .clkEn     (clkEn),
    .oscEn     (oscEn),
    .adcStart  (adcStart)
  );

  assign {clkEnCpu, clkEnFlash, clkEnIo, clkEnAdc, clkEnAsync} = clkEn;
endmodule

// File: rtl/spc_checker.sv
module spc_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regRdData,
  input logic       sleepInstr,
  input logic       clkEnCpu,
  input logic       clkEnFlash,
  input logic       clkEnIo,
  input logic       clkEnAdc,
  input logic       clkEnAsync,
  input logic       oscEn,
  input logic       adcStart,
  input logic       cpuHold,
  input logic       irqGo,
  input logic       rstVecGo
);
  AST_SE_LOW_NO_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuHold && sleepInstr && !regRdData[5]) |=> !cpuHold) else $error("AST_SE_LOW_NO_SLEEP"); // R1

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[7:6] == 2'b00) && (regRdData[2:0] == 3'b000)) else $error("AST_RSVD_ZERO"); // R2

  AST_CPU_FLASH_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    !clkEnCpu |-> (!clkEnFlash && cpuHold)) else $error("AST_CPU_FLASH_TOGETHER"); // R3

  AST_OSC_OFF_ALL_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> (!clkEnIo && !clkEnAdc && !clkEnAsync && !clkEnCpu)) else $error("AST_OSC_OFF_ALL_GATED"); // R5

  AST_ADC_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart) else $error("AST_ADC_PULSE_ONE"); // R8

  AST_HALT_FOUR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqGo) |-> (!cpuHold && $past(cpuHold && clkEnCpu, 1) && $past(cpuHold && clkEnCpu, 4)
                      && $past(cpuHold && !clkEnCpu, 5))) else $error("AST_HALT_FOUR"); // R9

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    rstVecGo |-> (!irqGo && !cpuHold)) else $error("AST_PULSE_EXCL"); // R10
endmodule

bind sleep_power_ctrl spc_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .regRdData  (regRdData),
  .sleepInstr (sleepInstr),
  .clkEnCpu   (clkEnCpu),
  .clkEnFlash (clkEnFlash),
  .clkEnIo    (clkEnIo),
  .clkEnAdc   (clkEnAdc),
  .clkEnAsync (clkEnAsync),
  .oscEn      (oscEn),
  .adcStart   (adcStart),
  .cpuHold    (cpuHold),
  .irqGo      (irqGo),
  .rstVecGo   (rstVecGo)
);

// File: tb/tb_sleep_power_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_power_ctrl;
  localparam int TICKS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       sleepInstr = 1'b0;
  logic       adcEnable = 1'b1;
  logic [6:0] wakeReq = '0;
  logic       rstReq = 1'b0;
  logic       asyncTick = 1'b1;
  logic clkEnCpu, clkEnFlash, clkEnIo, clkEnAdc, clkEnAsync;
  logic oscEn, adcStart, cpuHold, irqGo, rstVecGo;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  sleep_power_ctrl #(.STARTUP_TICKS(TICKS), .HALT_CYCLES(4)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .sleepInstr(sleepInstr), .adcEnable(adcEnable),
    .wakeReq(wakeReq), .rstReq(rstReq), .asyncTick(asyncTick),
    .clkEnCpu(clkEnCpu), .clkEnFlash(clkEnFlash), .clkEnIo(clkEnIo),
    .clkEnAdc(clkEnAdc), .clkEnAsync(clkEnAsync), .oscEn(oscEn),
    .adcStart(adcStart), .cpuHold(cpuHold), .irqGo(irqGo), .rstVecGo(rstVecGo)
  );

  // {mode[1:0], wake[6:0], expectWake, clocks{cpu,flash,io,adc,async}, osc}
  localparam logic [15:0] VEC [12] = '{
    {2'd0, 7'h40, 1'b1, 5'b00111, 1'b1},
    {2'd0, 7'h08, 1'b1, 5'b00111, 1'b1},
    {2'd1, 7'h01, 1'b1, 5'b00011, 1'b1},
    {2'd1, 7'h08, 1'b0, 5'b00011, 1'b1},
    {2'd1, 7'h40, 1'b0, 5'b00011, 1'b1},
    {2'd1, 7'h02, 1'b1, 5'b00011, 1'b1},
    {2'd2, 7'h08, 1'b0, 5'b00000, 1'b0},
    {2'd2, 7'h01, 1'b0, 5'b00000, 1'b0},
    {2'd2, 7'h10, 1'b1, 5'b00000, 1'b0},
    {2'd3, 7'h02, 1'b0, 5'b00000, 1'b1},
    {2'd3, 7'h04, 1'b1, 5'b00000, 1'b1},
    {2'd0, 7'h01, 1'b1, 5'b00111, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] clocks();
    return {clkEnCpu, clkEnFlash, clkEnIo, clkEnAdc, clkEnAsync};
  endfunction

  function automatic string modeReq(input logic [1:0] m);
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic enterSleep(input logic [1:0] m);
    regWrEn = 1'b1;
    regWrData = {2'b00, 1'b1, m, 3'b000};
    tick();
    regWrEn = 1'b0;
    sleepInstr = 1'b1;
    tick();
    sleepInstr = 1'b0;
  endtask

  task automatic recover();
    wakeReq = 7'h20;
    asyncTick = 1'b1;
    for (int k = 0; k < 40; k++) begin
      if (!cpuHold) break;
      tick();
    end
    wakeReq = '0;
    tick();
  endtask

  initial begin
    #(5.0 * 100000);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    // reset state, R2
    check("R2 reset read", regRdData, 8'h00);
    check("R2 reset clocks", {cpuHold, clocks(), oscEn}, 7'b0111111);

    // R2 register layout
    regWrEn = 1'b1; regWrData = 8'hFF; tick();
    regWrEn = 1'b0;
    check("R2 readback", regRdData, 8'h38);

    // R1 strobe ignored with SE low
    regWrEn = 1'b1; regWrData = 8'h10; tick();
    regWrEn = 1'b0; sleepInstr = 1'b1; tick();
    sleepInstr = 1'b0;
    check("R1 no hold", {cpuHold, adcStart}, 2'b00);
    check("R1 clocks on", clocks(), 5'b11111);
    tick();
    check("R1 still run", cpuHold, 1'b0);

    // table sweep over modes and wake sources
    for (int i = 0; i < 12; i++) begin
      logic [15:0] v;
      logic [1:0]  m;
      v = VEC[i];
      m = v[15:14];
      asyncTick = 1'b1;
      enterSleep(m);
      check("R8 adc pulse", adcStart, (m < 2'd2) ? 1'b1 : 1'b0);
      check({modeReq(m), " sleep clocks"}, {cpuHold, clocks(), oscEn}, {1'b1, v[5:0]});
      wakeReq = v[13:7];
      tick();
      wakeReq = '0;
      if (v[6]) begin
        if (m == 2'd2)
          check("R7 startup begins", {cpuHold, clkEnCpu, oscEn}, 3'b101);
        else
          check({modeReq(m), " woke"}, {cpuHold, clocks(), oscEn}, 7'b1111111);
      end else begin
        check({modeReq(m), " filtered"}, {cpuHold, clocks(), oscEn}, {1'b1, v[5:0]});
      end
      recover();
    end

    // R9 four-cycle hold, Idle
    enterSleep(2'd0);
    wakeReq = 7'h40; tick(); wakeReq = '0;
    for (int k = 0; k < 3; k++) begin
      check("R9 hold with clocks", {cpuHold, clkEnCpu, irqGo}, 3'b110);
      tick();
    end
    check("R9 hold 4th", {cpuHold, clkEnCpu, irqGo}, 3'b110);
    tick();
    check("R9 resume pulse", {cpuHold, irqGo, rstVecGo}, 3'b010);
    tick();
    check("R9 pulse one cycle", irqGo, 1'b0);

    // R7 start-up counting, deep off
    enterSleep(2'd2);
    asyncTick = 1'b0;
    wakeReq = 7'h10; tick(); wakeReq = '0;
    repeat (5) tick();
    check("R7 no tick no clocks", {cpuHold, clkEnCpu, oscEn}, 3'b101);
    asyncTick = 1'b1;
    repeat (TICKS - 1) tick();
    check("R7 before last tick", {cpuHold, clkEnCpu}, 2'b10);
    tick();
    check("R7 after last tick", {cpuHold, clkEnCpu, clkEnIo}, 3'b111);
    recover();

    // R10 reset wake from idle
    enterSleep(2'd0);
    rstReq = 1'b1; tick(); rstReq = 1'b0;
    check("R10 idle reset", {cpuHold, irqGo, rstVecGo}, 3'b001);

    // R10 reset plus interrupt during deep off start-up
    enterSleep(2'd2);
    asyncTick = 1'b0;
    rstReq = 1'b1; wakeReq = 7'h20; tick();
    rstReq = 1'b0; wakeReq = '0;
    check("R10 deep startup", {cpuHold, clkEnCpu, rstVecGo}, 3'b100);
    asyncTick = 1'b1;
    repeat (TICKS - 1) tick();
    check("R10 deep wait", {cpuHold, rstVecGo}, 2'b10);
    tick();
    check("R10 deep reset vector", {cpuHold, clkEnCpu, irqGo, rstVecGo}, 4'b0101);
    tick();
    check("R10 no late irq", {cpuHold, irqGo, rstVecGo}, 3'b000);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule